// File: doc/BRIEF.md
# Auto-Reload Timebase Timer

This block is an up-counting timebase with automatic reload. A prescaled tick enable advances the counter by one. When a tick arrives while the counter sits at its all-ones value, the counter takes the value held in a software-written reload register, so the reload value sets the period. Each of these overflows sets a status flag. Software clears the flag by reading the control/status register. The block raises an interrupt request while the flag and its enable bit are both set and the global interrupt mask is clear.

A small register bus gives access to two registers: control/status (address 0) and reload (address 1). A power-mode input picks run, wait, active-halt or halt. Only halt freezes the counter. A wake output tells the power controller that a pending interrupt may end wait mode. It never asserts in active-halt or halt.

Top module: `tbase_reload_timer`

## Requirements
- R1: After a synchronous reset, both registers read 0x00, `irq_o` and `wake_o` are low, and the counter holds 0, so the first overflow comes on the 256th tick.
- R2: Each cycle with `tick_en` high, and `pm_mode` not halt, adds one to the counter. A tick while the counter is 0xFF is an overflow: the counter loads the reload value. The period is therefore 256 minus the reload value in ticks.
- R3: An overflow sets the flag (control/status bit 0). A read of address 0 returns the flag's current value and clears it for the next cycle. `bus_rdata` is 0 in any cycle without a read (`bus_sel` and `bus_rd` both high).
- R4: If a read of address 0 and an overflow happen in the same cycle, the flag stays set.
- R5: A write to address 0 updates only the interrupt enable (bit 1). Writing bit 0 leaves the flag unchanged, and bits 7:2 read as zero.
- R6: Address 1 is a read/write reload register. Writing it does not change the current count. The new value is used from the next overflow on.
- R7: `irq_o` is high exactly when flag, enable and a low `gmask` are all true.
- R8: `pm_mode` encoding: 0 run, 1 wait, 2 active-halt, 3 halt. In halt the counter does not move, whatever `tick_en` does. In the other three modes it counts as in R2.
- R9: `wake_o` is high only when `irq_o` is high and `pm_mode` is wait. It stays low in active-halt and halt.
- R10: With `tick_en` low the counter keeps its value, so gaps between ticks only stretch the period in cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled count tick |
| pm_mode | input | 2 | Power mode: 0 run, 1 wait, 2 active-halt, 3 halt |
| gmask | input | 1 | Global interrupt mask, high blocks `irq_o` |
| bus_sel | input | 1 | Register access select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 control/status, 1 reload |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request for wait mode |

## Verification
The bench aims at the cycle where a status read and an overflow meet. A design that lets the read win would lose the event and drop the flag. It writes the reload register in the middle of a period. A design that reloads at once would end that period early. It uses a reload value of 0xFF, so every tick overflows, and it puts all four power modes in front of a pending interrupt. A wrong design would either count through halt, stop in active-halt, or ask for a wake outside wait. Writes of ones to the flag and to the reserved bits show any design that lets software set the flag or leaks those bits.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    // Power mode encoding seen on the pm_mode port
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_WAIT  = 2'd1,
        PM_AHALT = 2'd2,
        PM_HALT  = 2'd3
    } pm_e;

    // Register addresses
    localparam logic REG_CSR = 1'b0;
    localparam logic REG_RLD = 1'b1;

    // Bit positions inside the control/status register
    localparam int CSR_FLAG_BIT = 0;
    localparam int CSR_IEN_BIT  = 1;

    typedef struct packed {
        logic ien;
        logic flag;
    } csr_t;

    typedef struct packed {
        logic csr_rd;
        logic csr_wr;
        logic rld_rd;
        logic rld_wr;
    } bus_dec_t;

    function automatic bus_dec_t bus_decode(input logic sel, input logic rd,
                                            input logic wr, input logic addr);
        bus_dec_t d;
        d.csr_rd = sel && rd && (addr == REG_CSR);
        d.csr_wr = sel && wr && (addr == REG_CSR);
        d.rld_rd = sel && rd && (addr == REG_RLD);
        d.rld_wr = sel && wr && (addr == REG_RLD);
        return d;
    endfunction

    // Halt is the only mode that stops the count
    function automatic logic pm_counts(input pm_e m);
        return (m != PM_HALT);
    endfunction

    // Only wait mode may be left by this timer's interrupt
    function automatic logic pm_wakeable(input pm_e m);
        return (m == PM_WAIT);
    endfunction

endpackage

// File: rtl/tbt_counter.sv
module tbt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] CNT_TOP = '1;

    logic [W-1:0] cnt_q;

    assign ovf_o = adv && (cnt_q == CNT_TOP);
    assign cnt_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= ovf_o ? reload_i : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tbt_regs.sv
module tbt_regs
    import tbt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic         rd,
    input  logic         wr,
    input  logic         addr,
    input  logic [W-1:0] wdata,
    input  logic         ovf_i,
    output logic [W-1:0] reload_o,
    output csr_t         csr_o,
    output logic [W-1:0] rdata
);
    localparam int PAD_W = W - 2;

    bus_dec_t     dec;
    csr_t         csr_q;
    logic [W-1:0] reload_q;

    assign dec      = bus_decode(sel, rd, wr, addr);
    assign csr_o    = csr_q;
    assign reload_o = reload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            csr_q    <= '0;
        end else begin
            if (dec.rld_wr) begin
                reload_q <= wdata;
            end
            if (dec.csr_wr) begin
                csr_q.ien <= wdata[CSR_IEN_BIT];
            end
            // a new overflow beats the read-side clear
            if (ovf_i) begin
                csr_q.flag <= 1'b1;
            end else if (dec.csr_rd) begin
                csr_q.flag <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (dec.csr_rd) begin
            rdata = {{PAD_W{1'b0}}, csr_q.ien, csr_q.flag};
        end else if (dec.rld_rd) begin
            rdata = reload_q;
        end
    end
endmodule

// File: rtl/tbt_pm_ctrl.sv
module tbt_pm_ctrl
    import tbt_pkg::*;
(
    input  pm_e  pm,
    input  logic tick_en,
    input  csr_t csr,
    input  logic gmask,
    output logic adv,
    output logic irq,
    output logic wake
);
    assign adv  = tick_en && pm_counts(pm);
    assign irq  = csr.flag && csr.ien && !gmask;
    assign wake = irq && pm_wakeable(pm);
endmodule

// File: rtl/tbase_reload_timer.sv
module tbase_reload_timer
    import tbt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic [1:0]   pm_mode,
    input  logic         gmask,
    input  logic         bus_sel,
    input  logic         bus_rd,
    input  logic         bus_wr,
    input  logic         bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq_o,
    output logic         wake_o
);
    pm_e          pm_w;
    csr_t         csr_w;
    logic         flag_w;
    logic         adv_w;
    logic         ovf_w;
    logic [W-1:0] cnt_w;
    logic [W-1:0] reload_w;

    assign pm_w   = pm_e'(pm_mode);
    assign flag_w = csr_w.flag;

    tbt_pm_ctrl u_pm (
        .pm      (pm_w),
        .tick_en (tick_en),
        .csr     (csr_w),
        .gmask   (gmask),
        .adv     (adv_w),
        .irq     (irq_o),
        .wake    (wake_o)
    );

    tbt_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv_w),
        .reload_i (reload_w),
        .cnt_o    (cnt_w),
        .ovf_o    (ovf_w)
    );

    tbt_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sel      (bus_sel),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ovf_i    (ovf_w),
        .reload_o (reload_w),
        .csr_o    (csr_w),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/tbt_checker.sv
module tbt_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_en,
    input logic [1:0]   pm_mode,
    input logic         gmask,
    input logic         bus_sel,
    input logic         bus_rd,
    input logic         bus_addr,
    input logic [W-1:0] bus_rdata,
    input logic         irq_o,
    input logic         wake_o,
    input logic [W-1:0] cnt,
    input logic         ovf,
    input logic         flag
);
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (!gmask && flag));

    p_wake_wait_only_r9: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (pm_mode == 2'd1 && irq_o));

    p_halt_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (pm_mode == 2'd3) |=> $stable(cnt));

    p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt));

    p_ovf_keeps_flag_r4: assert property (@(posedge clk) disable iff (rst)
        ovf |=> flag);

    p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_rd && !bus_addr && !ovf) |=> !flag);

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_rd && !bus_addr) |-> (bus_rdata[W-1:2] == '0));

    p_idle_rdata_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_rd) |-> (bus_rdata == '0));
endmodule

bind tbase_reload_timer tbt_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .pm_mode   (pm_mode),
    .gmask     (gmask),
    .bus_sel   (bus_sel),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .cnt       (cnt_w),
    .ovf       (ovf_w),
    .flag      (flag_w)
);

// File: tb/tbase_reload_timer_tb_top.sv
`timescale 1ns/100ps
module tbase_reload_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [1:0] pm_mode = 2'd0;
    logic       gmask = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_o;
    logic       wake_o;

    int vectors = 0;
    int fails = 0;
    string phase = "R1 reset";

    // behavioural reference state
    int m_cnt = 0;
    int m_rel = 0;
    bit m_flag = 0;
    bit m_ien = 0;

    always #2.5 clk = ~clk;

    tbase_reload_timer #(.W(8)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .pm_mode(pm_mode),
        .gmask(gmask), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: compare outputs with the model, then advance the model
    task automatic cyc();
        bit      e_irq, e_wake, ovf, rd_csr;
        int      e_rd;
        #1;
        e_irq  = m_flag && m_ien && !gmask;
        e_wake = e_irq && (pm_mode == 2'd1);
        e_rd   = 0;
        if (bus_sel && bus_rd) e_rd = bus_addr ? m_rel : ((m_ien ? 2 : 0) + (m_flag ? 1 : 0));
        check(irq_o === e_irq, {phase, " irq R7"}, irq_o, e_irq);
        check(wake_o === e_wake, {phase, " wake R9"}, wake_o, e_wake);
        check(bus_rdata === e_rd[7:0], {phase, " rdata R3/R6"}, bus_rdata, e_rd);
        @(posedge clk);
        if (rst) begin
            m_cnt = 0; m_rel = 0; m_flag = 0; m_ien = 0;
        end else begin
            ovf    = tick_en && pm_mode != 2'd3 && m_cnt == 255;
            rd_csr = bus_sel && bus_rd && !bus_addr;
            if (tick_en && pm_mode != 2'd3) m_cnt = ovf ? m_rel : m_cnt + 1;
            if (bus_sel && bus_wr && bus_addr) m_rel = bus_wdata;
            if (bus_sel && bus_wr && !bus_addr) m_ien = bus_wdata[1];
            if (ovf) m_flag = 1;
            else if (rd_csr) m_flag = 0;
        end
        @(negedge clk);
    endtask

    task automatic bus_idle();
        bus_sel = 0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        bus_idle(); tick_en = 0;
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic tk(input int n);
        bus_idle(); tick_en = 1;
        for (int i = 0; i < n; i++) cyc();
        tick_en = 0;
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        tick_en = 0; bus_sel = 1; bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
        cyc();
        bus_idle();
    endtask

    task automatic peek(input bit a, input logic [7:0] exp, input string tag);
        tick_en = 0; bus_sel = 1; bus_rd = 1; bus_wr = 0; bus_addr = a;
        #1 check(bus_rdata === exp, tag, bus_rdata, exp);
        cyc();
        bus_idle();
    endtask

    task automatic read_with_tick(input logic [7:0] exp, input string tag);
        tick_en = 1; bus_sel = 1; bus_rd = 1; bus_wr = 0; bus_addr = 0;
        #1 check(bus_rdata === exp, tag, bus_rdata, exp);
        cyc();
        bus_idle(); tick_en = 0;
    endtask

    task automatic expect_irq(input bit ei, input bit ew, input string tag);
        bus_idle(); tick_en = 0;
        #1;
        check(irq_o === ei, {tag, " irq"}, irq_o, ei);
        check(wake_o === ew, {tag, " wake"}, wake_o, ew);
        cyc();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(3);
        rst = 0;
        phase = "R1";
        peek(0, 8'h00, "R1 csr after reset");
        peek(1, 8'h00, "R1 reload after reset");
        expect_irq(0, 0, "R1 outputs after reset");

        phase = "R5";
        wr(0, 8'hFD);
        peek(0, 8'h00, "R5 flag write ignored");
        wr(0, 8'hFF);
        peek(0, 8'h02, "R5 enable set reserved zero");

        phase = "R2";
        tk(255);
        peek(0, 8'h02, "R2 no overflow before 256th tick");
        tk(1);
        peek(0, 8'h03, "R2 overflow on 256th tick");
        peek(0, 8'h02, "R3 flag cleared by read");

        phase = "R6";
        wr(1, 8'hF0);
        peek(1, 8'hF0, "R6 reload readback");
        tk(255);
        peek(0, 8'h02, "R6 current count kept after write");
        tk(1);
        peek(0, 8'h03, "R6 overflow at old period end");
        tk(15);
        peek(0, 8'h02, "R6 period 16 not yet");
        tk(1);
        peek(0, 8'h03, "R6 period 16 reached");
        tk(3);
        wr(1, 8'h80);
        tk(12);
        peek(0, 8'h02, "R6 mid-period write no early end");
        tk(1);
        peek(0, 8'h03, "R6 mid-period write finishes old period");
        tk(127);
        peek(0, 8'h02, "R6 new period 128 not yet");
        wr(1, 8'hF0);
        tk(1);

        phase = "R7";
        expect_irq(1, 0, "R7 irq raised");
        gmask = 1;
        expect_irq(0, 0, "R7 masked");
        gmask = 0;
        wr(0, 8'h00);
        expect_irq(0, 0, "R7 enable off");
        wr(0, 8'h02);
        expect_irq(1, 0, "R7 enable back on");

        phase = "R9";
        pm_mode = 2'd1;
        expect_irq(1, 1, "R9 wake in wait");
        pm_mode = 2'd2;
        expect_irq(1, 0, "R9 no wake in active-halt");
        pm_mode = 2'd3;
        expect_irq(1, 0, "R9 no wake in halt");
        pm_mode = 2'd0;

        phase = "R8";
        peek(0, 8'h03, "R8 flag before halt");
        pm_mode = 2'd3;
        tk(40);
        peek(0, 8'h02, "R8 halt freezes count");
        pm_mode = 2'd2;
        tk(15);
        peek(0, 8'h02, "R8 active-halt not yet");
        tk(1);
        peek(0, 8'h03, "R8 active-halt counts");
        pm_mode = 2'd1;
        tk(15);
        peek(0, 8'h02, "R8 wait not yet");
        tk(1);
        peek(0, 8'h03, "R8 wait counts");
        pm_mode = 2'd3;
        tk(10);
        pm_mode = 2'd0;
        tk(15);
        peek(0, 8'h02, "R8 halt resumes not yet");
        tk(1);
        peek(0, 8'h03, "R8 halt resumes exact");

        phase = "R10";
        for (int i = 0; i < 15; i++) begin
            tk(1);
            idle(2);
        end
        peek(0, 8'h02, "R10 sparse ticks not yet");
        tk(1);
        peek(0, 8'h03, "R10 sparse ticks overflow");

        phase = "R4";
        wr(1, 8'hFF);
        tk(16);
        for (int i = 0; i < 4; i++) read_with_tick(8'h03, "R4 read with overflow keeps flag");
        peek(0, 8'h03, "R4 flag held after last clash");
        peek(0, 8'h02, "R3 clear after clash ends");
        idle(4);

        summary();
        $finish;
    end
endmodule